// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of samples by a fixed number of clock cycles. It behaves like a long shift register, but it does not move data through a chain of flip-flops. Each sample is written once into a two-port storage array and read back later. Two address counters walk through the array in step, one for writing and one for reading, and they keep a constant distance between them. For long delays this uses far less area than a register chain.

A new sample is taken on every clock, and a delayed sample leaves on every clock. The sample width and the delay depth are parameters. The depth must be a power of two and at least four. Storage holds `DEPTH` entries, and the registered read port completes a delay of exactly `DEPTH` cycles. Until `DEPTH` samples have entered after a reset, the output holds whatever the array held before, so users must qualify it with their own count.

Top module: `ram_delay_line`

## Requirements
- R1: While synchronous reset is asserted, the output is all zeros from the clock edge after reset is sampled.
- R2: On reset the write address goes to the last entry (all ones) and the read address goes to the first entry (all zeros).
- R3: Outside reset, both addresses advance by exactly one entry on every clock edge.
- R4: Each address wraps from the last entry (DEPTH-1) back to entry zero.
- R5: The read address always stays exactly one entry ahead of the write address, modulo DEPTH.
- R6: The sample presented on `din` before clock edge k appears on `dout` immediately after edge k+DEPTH-1, which is a delay of exactly DEPTH cycles. This holds for every k at least zero, where edge 0 is the first edge with reset low.
- R7: A reset in the middle of a stream restarts the timing. The first sample after reset release is the first one delivered, DEPTH cycles later, and no earlier data appears in its place.
- R8: The delay stays exact and gap-free over a run that covers several full passes of both addresses around the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WIDTH | Sample accepted on every rising edge |
| dout | output | WIDTH | Sample accepted DEPTH cycles earlier (registered) |

## Verification
In every cycle, the array takes a write to one entry while the registered read fetches the neighbouring entry. That entry is the oldest sample, and it is overwritten on the very next edge. So the last read of a slot and the first write to it fall on back-to-back edges, and they coincide with both counters crossing the wrap point once per pass. The bench streams ramps and alternating and walking patterns long enough to pass the wrap many times. A scoreboard compares each delivered sample against the value queued exactly DEPTH edges earlier. Any off-by-one in read-before-overwrite ordering or in the wrap therefore shows up as a wrong or repeated value. A reset in mid-stream checks that the restart discards old array contents.

// File: rtl/ram_delay_pkg.sv
package ram_delay_pkg;

  // Which end of the array a pointer counter starts from after reset.
  typedef enum logic {
    START_FIRST = 1'b0,
    START_LAST  = 1'b1
  } ptr_start_e;

  // Number of address bits needed to index a given number of entries.
  function automatic int unsigned addr_bits(input int unsigned entries);
    return (entries <= 1) ? 1 : $clog2(entries);
  endfunction

  // Next address along a circular array of 'entries' slots.
  function automatic int unsigned step_addr(input int unsigned cur,
                                            input int unsigned entries);
    return (cur >= entries - 1) ? 0 : cur + 1;
  endfunction

  // Input-to-output delay, in cycles, for a line of 'entries' slots:
  // (entries-1) cycles of pointer spacing plus the read register.
  function automatic int unsigned lag_cycles(input int unsigned entries);
    return (entries - 1) + 1;
  endfunction

  // True when a depth is a power of two and large enough to be useful.
  function automatic bit depth_ok(input int unsigned entries);
    return (entries >= 4) && ((entries & (entries - 1)) == 0);
  endfunction

endpackage

// File: rtl/dl_ptr_counter.sv
module dl_ptr_counter
  import ram_delay_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter ptr_start_e  START = START_FIRST,
  localparam int unsigned AW   = addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] reset_val;
  logic [AW-1:0] next_val;

  generate
    if (START == START_LAST) begin : g_start_last
      assign reset_val = AW'(DEPTH - 1);
    end else begin : g_start_first
      assign reset_val = '0;
    end
  endgenerate

  assign next_val = AW'(step_addr(32'(addr), DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= reset_val;
    end else begin
      addr <= next_val;
    end
  end

endmodule

// File: rtl/dl_dual_port_ram.sv
module dl_dual_port_ram
  import ram_delay_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  // Write port: one entry per cycle, storage itself is never reset.
  always_ff @(posedge clk) begin
    store[waddr] <= wdata;
  end

  // Read port: registered, cleared by reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= store[raddr];
    end
  end

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line
  import ram_delay_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned AW = addr_bits(DEPTH);

  generate
    if (!depth_ok(DEPTH)) begin : g_bad_depth
      $error("ram_delay_line: DEPTH must be a power of two and at least 4");
    end
  endgenerate

  // Named internal events, observed by the bound checker.
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  // Write pointer begins on the last entry, read pointer on the first,
  // so the read side trails the newest sample by DEPTH-1 entries.
  dl_ptr_counter #(
    .DEPTH (DEPTH),
    .START (START_LAST)
  ) u_wr_ptr (
    .clk  (clk),
    .rst  (rst),
    .addr (wr_addr)
  );

  dl_ptr_counter #(
    .DEPTH (DEPTH),
    .START (START_FIRST)
  ) u_rd_ptr (
    .clk  (clk),
    .rst  (rst),
    .addr (rd_addr)
  );

  dl_dual_port_ram #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .waddr (wr_addr),
    .wdata (din),
    .raddr (rd_addr),
    .rdata (dout)
  );

endmodule

// File: rtl/dl_checker.sv
module dl_checker
  import ram_delay_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = addr_bits(DEPTH),
  localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic [AW-1:0]    wr_addr,
  input logic [AW-1:0]    rd_addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  // Shadow flip-flop chain and fill count since the last reset.
  logic [WIDTH-1:0] shadow [DEPTH];
  logic [FW-1:0]    fill;

  always_ff @(posedge clk) begin
    shadow[0] <= din;
    for (int i = 1; i < DEPTH; i++) shadow[i] <= shadow[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else if (fill != FULL) fill <= fill + 1'b1;
  end

  // R1
  rst_out_zero_chk: assert property (@(posedge clk)
    rst |=> (dout == '0));

  // R2
  ptr_init_chk: assert property (@(posedge clk)
    rst |=> (wr_addr == LAST && rd_addr == '0));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr) != LAST && $past(wr_addr) != LAST) |->
      (rd_addr == $past(rd_addr) + 1'b1 && wr_addr == $past(wr_addr) + 1'b1));

  // R4
  rd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr) == LAST) |-> (rd_addr == '0));

  // R4
  wr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_addr) == LAST) |-> (wr_addr == '0));

  // R5
  ptr_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_addr == wr_addr + 1'b1));

  // R6
  exact_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == FULL) |-> (dout == shadow[DEPTH-1]));

endmodule

bind ram_delay_line dl_checker #(
  .WIDTH (WIDTH),
  .DEPTH (DEPTH)
) u_dl_checker (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .dout    (dout),
  .wr_addr (wr_addr),
  .rd_addr (rd_addr)
);

// File: tb/ram_delay_line_test.sv
module ram_delay_line_test;

  localparam int WIDTH = 8;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;

  always #4 clk = ~clk;   // 125 MHz

  ram_delay_line #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (dout)
  );

  logic [WIDTH-1:0] expq[$];
  int    checks = 0;
  int    errors = 0;
  int    edges  = 0;
  string cur_req = "R6";
  bit    done = 1'b0;

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected %h", req, act, exp);
    end
  endtask

  // Monitor: samples at the falling edge, after the rising edge settled.
  // An exact lag of DEPTH edges also confirms R2, R3 and R5 at the ports.
  always @(negedge clk) begin
    if (rst) begin
      edges = 0;
      check("R1", dout, '0);
    end else begin
      edges++;
      if (edges >= DEPTH) begin
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL %s: dout=%h expected queued sample (none)", cur_req, dout);
        end else begin
          check(cur_req, dout, expq.pop_front());
        end
      end
    end
  end

  // Driver: changes inputs just after the falling edge.
  task automatic tick(input logic [WIDTH-1:0] v);
    @(negedge clk);
    #1;
    rst = 1'b0;
    din = v;
    expq.push_back(v);
  endtask

  task automatic hold_reset(input int n);
    @(negedge clk);
    #1;
    rst = 1'b1;
    din = '0;
    expq.delete();
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);

    // R4 R8: ramp over many passes of both pointers
    cur_req = "R8";
    for (int i = 0; i < 5 * DEPTH; i++) tick(WIDTH'(i * 7 + 3));

    // R6: alternating, walking-one and extreme patterns
    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) tick((i % 2) ? 8'hAA : 8'h55);
    for (int i = 0; i < WIDTH; i++) tick(WIDTH'(1) << i);
    for (int i = 0; i < 6; i++) tick((i % 3 == 0) ? 8'hFF : 8'h00);

    // R4: pointers cross the wrap repeatedly with distinct values
    cur_req = "R4";
    for (int i = 0; i < 2 * DEPTH; i++) tick(8'hF0 ^ WIDTH'(i));

    // R7: reset in mid-stream, then a fresh stream
    for (int i = 0; i < 7; i++) tick(8'hC0 + WIDTH'(i));
    hold_reset(2);
    cur_req = "R7";
    for (int i = 0; i < 2 * DEPTH; i++) tick(8'h30 + WIDTH'(i));

    // Drain so every queued sample is compared
    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) tick('0);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R6: watchdog expired, actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule